// File: doc/BRIEF.md
# Conversion Trigger and Pacing Controller

This block decides the moment at which an analog-to-digital conversion begins and when its result is written into the sample FIFO. It can take a start from three places: a host write to the data address, a rising edge on an external pacer pin, or a tick from an internal pacer divider. A two-bit source select chooses which of these is live. The paced sources are gated, and pacing runs only after it has been armed. Either a host data write in a paced mode or a rising edge on an external trigger pin arms it. The trigger edge is held in a latch until the host writes the digital output register.

A started conversion does not act at once. It waits for a free-running 1 MHz reference pulse train. On the first reference pulse after the start, the block issues a convert strobe. On the third pulse, it issues the FIFO write strobe, and the busy flag drops. A write to the interrupt/pacer control register stops any conversion in flight and disarms host pacing. A paced start that arrives while a conversion is busy is dropped and counted. When burst mode is enabled, conversions repeat back to back until the channel sequencer reports the end of the burst.

Top module: `conv_pacer_top`

## Requirements
- R1: The trigger select is the two-bit `trigSel`. With `trigSel[1]=0`, a `dataWrStb` pulse starts one conversion: `eocBusy` goes to 1. The cycle after the first `usTick` that follows the start, `convStb` pulses. The cycle after the third such tick, `fifoWrStb` pulses and `eocBusy` returns to 0.
- R2: With `trigSel[1]=1`, a `dataWrStb` pulse starts no conversion. Instead it arms pacing, and `pacingActive` reads 1.
- R3: With `trigSel=2'b11`, an armed `pacerTick` starts a conversion, and external pacer edges have no effect. With `trigSel=2'b10`, each rising edge of `extPacerPin` (after synchronisation) starts one conversion, and `pacerTick` has no effect.
- R4: A paced start that arrives while `eocBusy=1` is ignored and increments `missCount`. `missCount` saturates at its all-ones value.
- R5: A `ctrlWrStb` pulse ends any conversion in flight without a FIFO write (`eocBusy=0` the next cycle). It also disarms host-armed pacing, so later pacer ticks start nothing.
- R6: A rising edge on `extTrigPin` sets `trigLatched` and arms pacing. A `doutWrStb` pulse clears `trigLatched`, and paced starts then stop.
- R7: With `burstEn=1`, a FIFO write with `burstDone=0` starts the next conversion at once, and `eocBusy` stays 1. A FIFO write with `burstDone=1` ends the run.
- R8: When `ctrlWrStb` and the third counted `usTick` fall in the same cycle, the stop wins: no `fifoWrStb` pulse occurs.
- R9: A software start that arrives while a conversion is busy is ignored and is not counted in `missCount`.
- R10: After reset, `eocBusy`, `convStb`, `fifoWrStb`, `trigLatched` and `pacingActive` are 0, and `missCount` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| dataWrStb | input | 1 | Host write to the data address (start or internal trigger) |
| ctrlWrStb | input | 1 | Host write to the interrupt/pacer control register (stop) |
| doutWrStb | input | 1 | Host write to the digital output register (clears trigger latch) |
| trigSel | input | 2 | Trigger source: 0x software, 10 external pacer, 11 internal pacer |
| usTick | input | 1 | One-cycle pulse of the 1 MHz reference |
| pacerTick | input | 1 | One-cycle internal pacer tick |
| extPacerPin | input | 1 | Asynchronous external pacer pin |
| extTrigPin | input | 1 | Asynchronous external trigger/gate pin |
| burstEn | input | 1 | Burst mode enable |
| burstDone | input | 1 | Channel sequencer reports the last channel of the burst |
| convStb | output | 1 | Convert strobe, one cycle |
| fifoWrStb | output | 1 | FIFO write strobe, one cycle |
| eocBusy | output | 1 | End-of-conversion flag: 1 busy, 0 complete |
| trigLatched | output | 1 | External trigger latch state |
| pacingActive | output | 1 | Pacing is selected and armed |
| missCount | output | MISS_W | Saturating count of paced starts dropped while busy |

## Verification
Two functions can land in the same cycle: a stop write and the reference pulse that would complete a conversion. The bench provokes this by raising `ctrlWrStb` and the third `usTick` on the same clock. It then judges the outcome by the absence of `fifoWrStb` and by `eocBusy` reading 0. A second pairing is a paced tick that arrives while a conversion is busy. The bench judges it by checking that the in-flight conversion still completes on schedule and that `missCount` advances by exactly one.

// File: rtl/conv_pacer_pkg.sv
package conv_pacer_pkg;
  localparam logic [1:0] SEL_EXT_PACER = 2'b10;
  localparam logic [1:0] SEL_INT_PACER = 2'b11;

  typedef struct packed {
    logic swStart;
    logic pacedStart;
    logic stopNow;
  } pacerStrobes_t;
endpackage

// File: rtl/conv_pacer_sync.sv
module conv_pacer_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] riseOut
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    logic              prev;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chain <= '0;
        prev  <= 1'b0;
      end else begin
        chain <= {chain[STAGES-2:0], asyncIn[b]};
        prev  <= chain[STAGES-1];
      end
    end
    assign riseOut[b] = chain[STAGES-1] & ~prev;
  end
endmodule

// File: rtl/conv_pacer_ctrl.sv
module conv_pacer_ctrl
  import conv_pacer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          dataWrStb,
  input  logic          ctrlWrStb,
  input  logic          doutWrStb,
  input  logic [1:0]    trigSel,
  input  logic          pacerTick,
  input  logic          extPacerPin,
  input  logic          extTrigPin,
  output pacerStrobes_t strb,
  output logic          trigLatched,
  output logic          pacingActive
);
  logic [1:0] pinRise;
  logic       hostArmed;
  logic       trigLatch;
  logic       pacedEvent;

  conv_pacer_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({extTrigPin, extPacerPin}),
    .riseOut (pinRise)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostArmed <= 1'b0;
      trigLatch <= 1'b0;
    end else begin
      if (ctrlWrStb)                    hostArmed <= 1'b0;
      else if (dataWrStb && trigSel[1]) hostArmed <= 1'b1;
      if (doutWrStb)       trigLatch <= 1'b0;
      else if (pinRise[1]) trigLatch <= 1'b1;
    end
  end

  always_comb begin
    pacingActive = trigSel[1] && (hostArmed || trigLatch);
    unique case (trigSel)
      SEL_INT_PACER: pacedEvent = pacerTick;
      SEL_EXT_PACER: pacedEvent = pinRise[0];
      default:       pacedEvent = 1'b0;
    endcase
    strb.swStart    = dataWrStb && !trigSel[1];
    strb.pacedStart = pacingActive && pacedEvent;
    strb.stopNow    = ctrlWrStb;
  end

  assign trigLatched = trigLatch;
endmodule

// File: rtl/conv_pacer_dp.sv
module conv_pacer_dp
  import conv_pacer_pkg::*;
#(
  parameter int DELAY_PULSES = 3,
  parameter int MISS_W       = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pacerStrobes_t     strb,
  input  logic              usTick,
  input  logic              burstEn,
  input  logic              burstDone,
  output logic              convStb,
  output logic              fifoWrStb,
  output logic              eocBusy,
  output logic [MISS_W-1:0] missCount
);
  localparam int CNT_W = $clog2(DELAY_PULSES + 1);
  localparam logic [CNT_W-1:0] LAST_PULSE = CNT_W'(DELAY_PULSES - 1);

  logic [CNT_W-1:0] pulseCnt;
  logic             busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      pulseCnt  <= '0;
      convStb   <= 1'b0;
      fifoWrStb <= 1'b0;
    end else begin
      convStb   <= 1'b0;
      fifoWrStb <= 1'b0;
      if (strb.stopNow) begin
        busy     <= 1'b0;
        pulseCnt <= '0;
      end else if (busy) begin
        if (usTick) begin
          if (pulseCnt == '0) convStb <= 1'b1;
          if (pulseCnt == LAST_PULSE) begin
            fifoWrStb <= 1'b1;
            pulseCnt  <= '0;
            busy      <= burstEn && !burstDone;
          end else begin
            pulseCnt <= pulseCnt + 1'b1;
          end
        end
      end else if (strb.swStart || strb.pacedStart) begin
        busy     <= 1'b1;
        pulseCnt <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      missCount <= '0;
    end else if (strb.pacedStart && busy && !strb.stopNow && missCount != '1) begin
      missCount <= missCount + 1'b1;
    end
  end

  assign eocBusy = busy;
endmodule

// File: rtl/conv_pacer_top.sv
module conv_pacer_top
  import conv_pacer_pkg::*;
#(
  parameter int DELAY_PULSES = 3,
  parameter int MISS_W       = 8,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dataWrStb,
  input  logic              ctrlWrStb,
  input  logic              doutWrStb,
  input  logic [1:0]        trigSel,
  input  logic              usTick,
  input  logic              pacerTick,
  input  logic              extPacerPin,
  input  logic              extTrigPin,
  input  logic              burstEn,
  input  logic              burstDone,
  output logic              convStb,
  output logic              fifoWrStb,
  output logic              eocBusy,
  output logic              trigLatched,
  output logic              pacingActive,
  output logic [MISS_W-1:0] missCount
);
  pacerStrobes_t strb;

  conv_pacer_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .dataWrStb    (dataWrStb),
    .ctrlWrStb    (ctrlWrStb),
    .doutWrStb    (doutWrStb),
    .trigSel      (trigSel),
    .pacerTick    (pacerTick),
    .extPacerPin  (extPacerPin),
    .extTrigPin   (extTrigPin),
    .strb         (strb),
    .trigLatched  (trigLatched),
    .pacingActive (pacingActive)
  );

  conv_pacer_dp #(.DELAY_PULSES(DELAY_PULSES), .MISS_W(MISS_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .usTick    (usTick),
    .burstEn   (burstEn),
    .burstDone (burstDone),
    .convStb   (convStb),
    .fifoWrStb (fifoWrStb),
    .eocBusy   (eocBusy),
    .missCount (missCount)
  );
endmodule

// File: rtl/conv_pacer_chk.sv
module conv_pacer_chk #(
  parameter int MISS_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              ctrlWrStb,
  input logic              doutWrStb,
  input logic              convStb,
  input logic              fifoWrStb,
  input logic              eocBusy,
  input logic              trigLatched,
  input logic [MISS_W-1:0] missCount
);
  p_fifo_after_busy_r1: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrStb |-> $past(eocBusy));

  p_conv_after_busy_r1: assert property (@(posedge clk) disable iff (!rstN)
    convStb |-> $past(eocBusy));

  p_stop_ends_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWrStb |=> (!eocBusy && !fifoWrStb));

  p_miss_only_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(missCount) |-> $past(eocBusy));

  p_latch_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    doutWrStb |=> !trigLatched);
endmodule

bind conv_pacer_top conv_pacer_chk #(.MISS_W(MISS_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .ctrlWrStb   (ctrlWrStb),
  .doutWrStb   (doutWrStb),
  .convStb     (convStb),
  .fifoWrStb   (fifoWrStb),
  .eocBusy     (eocBusy),
  .trigLatched (trigLatched),
  .missCount   (missCount)
);

// File: tb/conv_pacer_top_tb_top.sv
`timescale 1ns/1ps
module conv_pacer_top_tb_top;
  localparam int MISS_W = 8;
  localparam int DELAY  = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dataWrStb = 0, ctrlWrStb = 0, doutWrStb = 0;
  logic [1:0] trigSel = 2'b00;
  logic usTick = 0, pacerTick = 0, extPacerPin = 0, extTrigPin = 0;
  logic burstEn = 0, burstDone = 0;
  logic convStb, fifoWrStb, eocBusy, trigLatched, pacingActive;
  logic [MISS_W-1:0] missCount;

  int nChecks = 0;
  int nFails = 0;
  int expMiss = 0;

  always #2.5 clk = ~clk;

  conv_pacer_top #(.DELAY_PULSES(DELAY), .MISS_W(MISS_W)) dut_i (
    .clk(clk), .rstN(rstN), .dataWrStb(dataWrStb), .ctrlWrStb(ctrlWrStb),
    .doutWrStb(doutWrStb), .trigSel(trigSel), .usTick(usTick),
    .pacerTick(pacerTick), .extPacerPin(extPacerPin), .extTrigPin(extTrigPin),
    .burstEn(burstEn), .burstDone(burstDone), .convStb(convStb),
    .fifoWrStb(fifoWrStb), .eocBusy(eocBusy), .trigLatched(trigLatched),
    .pacingActive(pacingActive), .missCount(missCount)
  );

  function automatic int satMiss(int prev, int add);
    int s = prev + add;
    return (s > (1 << MISS_W) - 1) ? (1 << MISS_W) - 1 : s;
  endfunction

  function automatic bit expFifo(int tickNo);
    return tickNo == DELAY;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic pulseData();  dataWrStb = 1; @(negedge clk); dataWrStb = 0; endtask
  task automatic pulseCtrl();  ctrlWrStb = 1; @(negedge clk); ctrlWrStb = 0; endtask
  task automatic pulseDout();  doutWrStb = 1; @(negedge clk); doutWrStb = 0; endtask
  task automatic pulseUs();    usTick = 1;    @(negedge clk); usTick = 0;    endtask
  task automatic pulsePacer(); pacerTick = 1; @(negedge clk); pacerTick = 0; endtask

  // three reference ticks; checks strobe placement of one conversion
  task automatic runConv(string req, int maxGap);
    for (int t = 1; t <= DELAY; t++) begin
      idle($urandom_range(maxGap, 0));
      pulseUs();
      check(req, "convStb", convStb, t == 1);
      check(req, "fifoWrStb", fifoWrStb, expFifo(t));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5a17));
    idle(3);
    // R10 reset state
    check("R10", "eocBusy", eocBusy, 0);
    check("R10", "convStb", convStb, 0);
    check("R10", "fifoWrStb", fifoWrStb, 0);
    check("R10", "trigLatched", trigLatched, 0);
    check("R10", "pacingActive", pacingActive, 0);
    check("R10", "missCount", missCount, 0);
    @(negedge clk) rstN = 1;
    idle(2);

    // R1 software start, random gaps and TS0 don't-care
    for (int i = 0; i < 20; i++) begin
      trigSel = {1'b0, 1'($urandom_range(1, 0))};
      pulseData();
      check("R1", "busy after start", eocBusy, 1);
      if (i % 4 == 0) begin
        pulsePacer();      // pacing not selected: no effect, no miss
        check("R1", "missCount", missCount, expMiss);
      end
      runConv("R1", 3);
      check("R1", "busy after fifo", eocBusy, 0);
    end

    // R9 software start while busy ignored, not counted
    trigSel = 2'b00;
    pulseData();
    pulseUs();
    pulseData();
    check("R9", "missCount", missCount, expMiss);
    pulseUs(); pulseUs();
    check("R9", "fifoWrStb", fifoWrStb, 1);
    pulseUs(); pulseUs(); pulseUs();
    check("R9", "no second conv", eocBusy, 0);

    // R2 data write in pacer mode arms only
    trigSel = 2'b11;
    pulseData();
    check("R2", "no start", eocBusy, 0);
    check("R2", "pacingActive", pacingActive, 1);

    // R3 internal pacer starts; ext pacer ignored
    pulsePacer();
    check("R3", "int pacer start", eocBusy, 1);
    // R4 tick while busy is missed
    pulsePacer();
    expMiss = satMiss(expMiss, 1);
    check("R4", "missCount", missCount, expMiss);
    runConv("R4", 2);
    extPacerPin = 1; idle(5);
    check("R3", "ext ignored in 11", eocBusy, 0);
    extPacerPin = 0; idle(4);

    // R3 external pacer mode
    trigSel = 2'b10;
    pulsePacer();
    check("R3", "pacerTick ignored in 10", eocBusy, 0);
    extPacerPin = 1; idle(5);
    check("R3", "ext edge start", eocBusy, 1);
    runConv("R3", 1);
    idle(3);
    check("R3", "one conv per edge", eocBusy, 0);
    extPacerPin = 0; idle(4);

    // R5 stop aborts and disarms
    trigSel = 2'b11;
    pulsePacer();
    pulseUs();
    pulseCtrl();
    check("R5", "busy cleared", eocBusy, 0);
    pulseUs(); pulseUs();
    check("R5", "no fifo", fifoWrStb, 0);
    check("R5", "disarmed", pacingActive, 0);
    pulsePacer();
    check("R5", "tick after stop", eocBusy, 0);

    // R6 external trigger latch
    extTrigPin = 1; idle(5);
    check("R6", "trigLatched", trigLatched, 1);
    pulsePacer();
    check("R6", "armed by trigger", eocBusy, 1);
    runConv("R6", 1);
    pulseDout();
    check("R6", "latch cleared", trigLatched, 0);
    pulsePacer();
    check("R6", "pacing ended", eocBusy, 0);
    extTrigPin = 0; idle(4);

    // R8 stop coincides with final reference tick
    trigSel = 2'b00;
    pulseData();
    pulseUs(); pulseUs();
    usTick = 1; ctrlWrStb = 1;
    @(negedge clk); usTick = 0; ctrlWrStb = 0;
    check("R8", "fifoWrStb", fifoWrStb, 0);
    check("R8", "eocBusy", eocBusy, 0);
    idle(1);
    check("R8", "fifoWrStb late", fifoWrStb, 0);

    // R7 burst
    burstEn = 1;
    pulseData();
    runConv("R7", 1);
    check("R7", "busy continues", eocBusy, 1);
    pulseUs();
    check("R7", "next convStb", convStb, 1);
    pulseUs();
    burstDone = 1;
    pulseUs();
    check("R7", "last fifo", fifoWrStb, 1);
    check("R7", "burst ended", eocBusy, 0);
    burstEn = 0; burstDone = 0;

    // R4 saturation of missed count
    trigSel = 2'b11;
    pulseData();
    pulsePacer();
    for (int k = 0; k < 260; k++) pulsePacer();
    expMiss = satMiss(expMiss, 260);
    check("R4", "missCount saturated", missCount, expMiss);
    runConv("R4", 0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule